// File: doc/BRIEF.md
# Triggered Sample Sequencer with Circular Result FIFO

This block is the first sample sequencer of an analog-to-digital converter controller, cut down to its digital bookkeeping. An external trigger line marks the moments at which a conversion is wanted. When the sequencer is switched on, each trigger produces one 10-bit result. The result goes into a 16-entry circular FIFO, and a raw interrupt bit is set. The analog front end is replaced by a small linear congruential noise source, so results are 0x200 plus a 3-bit pseudo-random term.

Software reaches the block through a simple register port. A read strobe pops the oldest result from the FIFO data register. A packed status word exposes both FIFO pointers and the empty and full flags. An enable register, raw and masked interrupt views, an interrupt mask and a write-one-to-clear interrupt register complete the programming model. The interrupt output is high while any enabled raw bit is set.

Top module: `adcseq_top`

## Requirements
- R1: After reset the FIFO status reads 0x0000_0100 (empty, both pointers 0). The enable, raw, mask, mux and control registers read 0, and `irq` is low.
- R2: A trigger while bit 0 of the enable register (offset 0x00) is clear has no effect. The FIFO status, the raw interrupt and the noise sequence all stay unchanged.
- R3: An accepted trigger writes one result and advances the write pointer (status bits 7:4) by one, modulo 16. It also clears the empty flag (bit 8). The result is 0x200 + bits 18:16 of the noise state. The noise state starts at 0 and is replaced by state*314159+1 (32 bits) before each use.
- R4: When the write pointer reaches the read pointer, the full flag (bit 12) is set. An accepted trigger while full stores nothing and leaves the pointers as they are, but it still advances the noise state and still sets the raw interrupt.
- R5: A read of the FIFO data register (offset 0x48) returns the oldest result and advances the read pointer (status bits 3:0) modulo 16. It clears the full flag, and it sets the empty flag when the read pointer meets the write pointer.
- R6: A read of the FIFO data register while empty returns 0 and leaves both pointers unchanged.
- R7: Each accepted trigger sets raw interrupt bit 0 (read at 0x04). Offset 0x0C reads raw AND mask, and `irq` is high exactly while that value is nonzero.
- R8: Writing ones to offset 0x0C clears the matching raw bits. If a trigger is accepted in the same cycle, the trigger wins and bit 0 stays set.
- R9: The enable register (0x00) and the mask register (0x08) keep only their low 4 bits.
- R10: The mux register (0x40) keeps only the bits under 0x33333333. The control register (0x44) keeps its low 4 bits.
- R11: Writes to the FIFO data and status offsets (0x48, 0x4C) change nothing. Reads of unmapped offsets, including the windows of the other sequencers (0x60 to 0xBF), return 0.
- R12: Read data appears on `reg_rdata` in the cycle after the read strobe, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | 1 | Conversion trigger; each high cycle is one trigger |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO at 0x48) |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Interrupt, high while raw AND mask is nonzero |

## Verification
A pointer that slips by one shows up in two places. The next status read has the wrong field, and every later pop returns a result one position off in the noise sequence. The scoreboard catches it at the first pop after the fault. A wrong full flag shows up when the FIFO fills: a 17th result is kept instead of dropped, or results are lost early, and the mismatch appears within one pass of draining. Noise advancing at the wrong time, or failing to advance on a dropped trigger, corrupts every value popped afterwards. An interrupt fault shows directly on `irq` in the cycle after the trigger or clear write.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 32;
    localparam int FIFO_DEPTH = 16;
    localparam int PTR_W      = $clog2(FIFO_DEPTH);
    localparam int NSEQ       = 4;

    // register offsets
    localparam logic [ADDR_W-1:0] OFS_ENABLE = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_MASKED = 8'h0C; // read masked, write-1 clears raw
    localparam logic [2:0]        SEQ0_WIN   = 3'b010; // 0x40..0x5F
    localparam logic [4:0]        SQ_MUX     = 5'h00;
    localparam logic [4:0]        SQ_CTL     = 5'h04;
    localparam logic [4:0]        SQ_DATA    = 5'h08;
    localparam logic [4:0]        SQ_STAT    = 5'h0C;

    localparam logic [DATA_W-1:0] MUX_KEEP   = 32'h3333_3333;
    localparam logic [31:0]       LCG_MULT   = 32'd314159;
    localparam logic [31:0]       LCG_INC    = 32'd1;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_ENABLE, SEL_RAW, SEL_MASK, SEL_MASKED,
        SEL_MUX, SEL_CTL, SEL_DATA, SEL_STAT
    } reg_sel_e;

    typedef struct packed {
        logic             full;
        logic             empty;
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
    } fifo_stat_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        s = SEL_NONE;
        if (a[7:5] == SEQ0_WIN) begin
            unique case (a[4:0])
                SQ_MUX:  s = SEL_MUX;
                SQ_CTL:  s = SEL_CTL;
                SQ_DATA: s = SEL_DATA;
                SQ_STAT: s = SEL_STAT;
                default: s = SEL_NONE;
            endcase
        end else begin
            unique case (a)
                OFS_ENABLE: s = SEL_ENABLE;
                OFS_RAW:    s = SEL_RAW;
                OFS_MASK:   s = SEL_MASK;
                OFS_MASKED: s = SEL_MASKED;
                default:    s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

    // full at bit 12, empty at bit 8, write pointer 7:4, read pointer 3:0
    function automatic logic [DATA_W-1:0] pack_status(input fifo_stat_t st);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[12]    = st.full;
        w[8]     = st.empty;
        w[7:4]   = st.head;
        w[3:0]   = st.tail;
        return w;
    endfunction

endpackage

// File: rtl/adcseq_noise.sv
module adcseq_noise
    import adcseq_pkg::*;
#(
    parameter logic [31:0] SEED     = 32'd0,
    parameter int          SAMPLE_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                step,
    output logic [SAMPLE_W-1:0] sample
);
    localparam logic [SAMPLE_W-1:0] BASE = SAMPLE_W'(10'h200);

    logic [31:0] state_q;
    logic [31:0] state_nxt;

    always_comb begin
        state_nxt = state_q * LCG_MULT + LCG_INC;
        sample    = BASE + SAMPLE_W'(state_nxt[18:16]);
    end

    always_ff @(posedge clk) begin
        if (rst)       state_q <= SEED;
        else if (step) state_q <= state_nxt;
    end
endmodule

// File: rtl/adcseq_fifo.sv
module adcseq_fifo
    import adcseq_pkg::*;
#(
    parameter int WIDTH = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] wdat,
    input  logic             pop,
    output logic [WIDTH-1:0] rdat,
    output fifo_stat_t       stat
);
    logic [WIDTH-1:0] mem [FIFO_DEPTH];
    logic [PTR_W-1:0] head_q, tail_q;
    logic             full_q;
    logic             empty;
    logic             push_ok, pop_ok;
    logic [PTR_W-1:0] head_inc, tail_inc;

    always_comb begin
        empty    = (head_q == tail_q) && !full_q;
        push_ok  = push && !full_q;
        pop_ok   = pop && !empty;
        head_inc = head_q + 1'b1;
        tail_inc = tail_q + 1'b1;
        rdat     = empty ? '0 : mem[tail_q];
        stat     = '{full: full_q, empty: empty, head: head_q, tail: tail_q};
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[head_q] <= wdat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            full_q <= 1'b0;
        end else begin
            if (push_ok) head_q <= head_inc;
            if (pop_ok)  tail_q <= tail_inc;
            if (push_ok && !pop_ok)      full_q <= (head_inc == tail_q);
            else if (pop_ok && !push_ok) full_q <= 1'b0;
        end
    end
endmodule

// File: rtl/adcseq_regs.sv
module adcseq_regs
    import adcseq_pkg::*;
#(
    parameter int SAMPLE_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic                rd,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [SAMPLE_W-1:0] fifo_rdat,
    input  fifo_stat_t          fifo_stat,
    input  logic                sample_evt,
    output logic                run0,
    output logic                raw0,
    output logic                mask0,
    output logic                pop,
    output logic [DATA_W-1:0]   rdata,
    output logic                irq
);
    reg_sel_e          sel;
    logic [NSEQ-1:0]   enable_q, raw_q, mask_q, raw_nxt, evt_vec;
    logic [NSEQ-1:0]   ctl_q;
    logic [DATA_W-1:0] mux_q;
    logic [DATA_W-1:0] rd_mux;

    // only sequencer 0 produces events; others tie off
    for (genvar g = 0; g < NSEQ; g++) begin : g_evt
        if (g == 0) begin : g_live
            assign evt_vec[g] = sample_evt;
        end else begin : g_tie
            assign evt_vec[g] = 1'b0;
        end
    end

    always_comb begin
        sel     = decode_addr(addr);
        pop     = rd && (sel == SEL_DATA);
        raw_nxt = raw_q;
        if (wr && sel == SEL_MASKED) raw_nxt = raw_nxt & ~wdata[NSEQ-1:0];
        raw_nxt = raw_nxt | evt_vec;
        unique case (sel)
            SEL_ENABLE: rd_mux = DATA_W'(enable_q);
            SEL_RAW:    rd_mux = DATA_W'(raw_q);
            SEL_MASK:   rd_mux = DATA_W'(mask_q);
            SEL_MASKED: rd_mux = DATA_W'(raw_q & mask_q);
            SEL_MUX:    rd_mux = mux_q;
            SEL_CTL:    rd_mux = DATA_W'(ctl_q);
            SEL_DATA:   rd_mux = DATA_W'(fifo_rdat);
            SEL_STAT:   rd_mux = pack_status(fifo_stat);
            default:    rd_mux = '0;
        endcase
        irq   = |(raw_q & mask_q);
        run0  = enable_q[0];
        raw0  = raw_q[0];
        mask0 = mask_q[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            raw_q    <= '0;
            mask_q   <= '0;
            ctl_q    <= '0;
            mux_q    <= '0;
            rdata    <= '0;
        end else begin
            raw_q <= raw_nxt;
            if (wr) begin
                unique case (sel)
                    SEL_ENABLE: enable_q <= wdata[NSEQ-1:0];
                    SEL_MASK:   mask_q   <= wdata[NSEQ-1:0];
                    SEL_MUX:    mux_q    <= wdata & MUX_KEEP;
                    SEL_CTL:    ctl_q    <= wdata[NSEQ-1:0];
                    default:    ;
                endcase
            end
            if (rd) rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
    import adcseq_pkg::*;
#(
    parameter int          SAMPLE_W   = 10,
    parameter logic [31:0] NOISE_SEED = 32'd0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        trig,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    logic                run0, raw0, mask0, fifo_pop, accept;
    logic [SAMPLE_W-1:0] sample, fifo_rdat;
    fifo_stat_t          fstat;
    logic [PTR_W-1:0]    head_w, tail_w;
    logic                full_w;

    assign accept = trig && run0;
    assign head_w = fstat.head;
    assign tail_w = fstat.tail;
    assign full_w = fstat.full;

    adcseq_noise #(.SEED(NOISE_SEED), .SAMPLE_W(SAMPLE_W)) u_noise (
        .clk(clk), .rst(rst), .step(accept), .sample(sample)
    );

    adcseq_fifo #(.WIDTH(SAMPLE_W)) u_fifo (
        .clk(clk), .rst(rst), .push(accept), .wdat(sample),
        .pop(fifo_pop), .rdat(fifo_rdat), .stat(fstat)
    );

    adcseq_regs #(.SAMPLE_W(SAMPLE_W)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
        .wdata(reg_wdata), .fifo_rdat(fifo_rdat), .fifo_stat(fstat),
        .sample_evt(accept), .run0(run0), .raw0(raw0), .mask0(mask0),
        .pop(fifo_pop), .rdata(reg_rdata), .irq(irq)
    );
endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk (
    input logic       clk,
    input logic       rst,
    input logic       trig,
    input logic       run0,
    input logic       pop,
    input logic [3:0] head,
    input logic [3:0] tail,
    input logic       full,
    input logic       raw0,
    input logic       irq
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (head == 4'd0 && tail == 4'd0 && !full && !irq));

    assert_idle_trig_R2: assert property (@(posedge clk) disable iff (rst)
        (trig && !run0) |=> $stable(head));

    assert_head_step_R3: assert property (@(posedge clk) disable iff (rst)
        (trig && run0 && !full) |=> (head == 4'($past(head) + 4'd1)));

    assert_drop_full_R4: assert property (@(posedge clk) disable iff (rst)
        (trig && run0 && full && !pop) |=> (full && $stable(head)));

    assert_full_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (pop && full) |=> !full);

    assert_empty_pop_R6: assert property (@(posedge clk) disable iff (rst)
        (pop && head == tail && !full) |=> $stable(tail));

    assert_raw_set_R7: assert property (@(posedge clk) disable iff (rst)
        (trig && run0) |=> raw0);
endmodule

bind adcseq_top adcseq_chk u_chk (
    .clk(clk), .rst(rst), .trig(trig), .run0(run0), .pop(fifo_pop),
    .head(head_w), .tail(tail_w), .full(full_w), .raw0(raw0), .irq(irq)
);

// File: tb/adcseq_top_test.sv
module adcseq_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    adcseq_top uut (
        .clk(clk), .rst(rst), .trig(trig), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    // scoreboard queues
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        pend = 1'b0;

    // reference model
    logic [31:0] m_noise = 32'd0;
    logic [31:0] m_fifo[$];
    bit          m_run = 1'b0;

    always @(posedge clk) pend <= reg_rd;

    always @(negedge clk) begin
        if (pend && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_tests++;
            if (reg_rdata !== e) begin
                n_fail++;
                $display("FAIL %s: got %h expected %h", t, reg_rdata, e);
            end
        end
    end

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic void model_trigger();
        if (m_run) begin
            m_noise = m_noise * 32'd314159 + 32'd1;
            if (m_fifo.size() < 16)
                m_fifo.push_back(32'h200 + {29'd0, m_noise[18:16]});
        end
    endfunction

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            trig = 1'b1;
            model_trigger();
            @(negedge clk);
            trig = 1'b0;
        end
    endtask

    task automatic pop_expect(input string t);
        logic [31:0] e;
        e = (m_fifo.size() > 0) ? m_fifo.pop_front() : 32'd0;
        rd_reg(8'h48, e, t);
    endtask

    task automatic chk_irq(input logic e, input string t);
        @(negedge clk);
        n_tests++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s: irq got %b expected %b", t, irq, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk_irq(1'b0, "R1");
        rd_reg(8'h4C, 32'h100, "R1");
        rd_reg(8'h00, 32'h0, "R1");
        rd_reg(8'h04, 32'h0, "R1");
        rd_reg(8'h08, 32'h0, "R1");
        rd_reg(8'h40, 32'h0, "R1");
        // R2 triggers ignored while disabled
        pulse(3);
        rd_reg(8'h4C, 32'h100, "R2");
        rd_reg(8'h04, 32'h0, "R2");
        // R9 enable and mask widths
        wr_reg(8'h00, 32'hFFFF_FFFF);
        m_run = 1'b1;
        rd_reg(8'h00, 32'hF, "R9");
        wr_reg(8'h08, 32'h31);
        rd_reg(8'h08, 32'h1, "R9");
        chk_irq(1'b0, "R7");
        // R3 pushes
        pulse(3);
        rd_reg(8'h4C, 32'h030, "R3");
        rd_reg(8'h04, 32'h1, "R7");
        rd_reg(8'h0C, 32'h1, "R7");
        chk_irq(1'b1, "R7");
        // R8 clear, then clear racing a trigger
        wr_reg(8'h0C, 32'h1);
        rd_reg(8'h04, 32'h0, "R8");
        chk_irq(1'b0, "R8");
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h0C; reg_wdata = 32'h1; trig = 1'b1;
        model_trigger();
        @(negedge clk);
        reg_wr = 1'b0; trig = 1'b0;
        rd_reg(8'h04, 32'h1, "R8");
        // R5 pops, R12 latency via scoreboard
        pop_expect("R5");
        pop_expect("R12");
        rd_reg(8'h4C, 32'h042, "R5");
        // R4 fill, then a dropped trigger
        pulse(14);
        rd_reg(8'h4C, 32'h1022, "R4");
        wr_reg(8'h0C, 32'h1);
        pulse(1);
        rd_reg(8'h4C, 32'h1022, "R4");
        rd_reg(8'h04, 32'h1, "R4");
        // R5 drain
        pop_expect("R5");
        rd_reg(8'h4C, 32'h023, "R5");
        for (int i = 0; i < 15; i++) pop_expect("R5");
        rd_reg(8'h4C, 32'h122, "R5");
        // R6 empty read
        pop_expect("R6");
        rd_reg(8'h4C, 32'h122, "R6");
        // R10 mux and control
        wr_reg(8'h40, 32'hFFFF_FFFF);
        rd_reg(8'h40, 32'h3333_3333, "R10");
        wr_reg(8'h44, 32'hFF);
        rd_reg(8'h44, 32'hF, "R10");
        // R11 ignored writes and unmapped reads
        wr_reg(8'h4C, 32'hFFFF_FFFF);
        wr_reg(8'h48, 32'h55);
        rd_reg(8'h4C, 32'h122, "R11");
        rd_reg(8'h60, 32'h0, "R11");
        rd_reg(8'h90, 32'h0, "R11");
        rd_reg(8'h10, 32'h0, "R11");
        // R4 noise advanced across the dropped trigger
        pulse(1);
        pop_expect("R4");
        rd_reg(8'h4C, 32'h133, "R3");
        // R2 disabled trigger leaves noise alone
        wr_reg(8'h00, 32'h0);
        m_run = 1'b0;
        pulse(2);
        wr_reg(8'h00, 32'h1);
        m_run = 1'b1;
        pulse(1);
        pop_expect("R2");
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule